// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A watchdog peripheral that counts down from a programmable start value and, unless software services it in time, first flags a timeout and then, on a second expiry that software has not acknowledged, asks the system for a reset. Software reaches it over a small 16-bit register bus with byte offsets. Reads come back combinationally from the addressed register. A write is taken on the clock edge while both select and write are high.

A prescaler divides the clock into ticks of `TICK_CYCLES` cycles. Each tick lowers a 10-bit counter by one. A tick that finds the counter at zero is an expiry, and the counter then restarts from the start value. The first expiry sets a timeout flag. An expiry that finds that flag still set raises a second-timeout flag and drives a one-cycle reset request, unless the reboot-block bit is set. Any write to the service register restarts the count. The halt bit freezes the count. After reset the block comes up halted, with reboots blocked.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0x0801: halt is bit 11 and reboot-block is bit 0, and both are 1. The counter and the start value both equal `RESET_INIT` (4), with the upper start-register bits at 0. The status register at 0x04 reads 0. The status register at 0x06 reads 0x0004, because the boot flag at bit 2 is set. `rst_req` is 0.
- R2: While halt is 0, the counter drops by exactly one every `TICK_CYCLES` clock cycles. While halt is 1, the counter holds its value.
- R3: A write of any data to offset 0x00 loads the counter with the start value and restarts the tick phase. A read of 0x00 returns the count in bits 9:0 and zeros above them.
- R4: At offset 0x12, bits 9:0 hold the start value and bits 15:10 store whatever is written to them. A write whose bits 9:0 are 0 to 3 leaves the start value unchanged.
- R5: A tick that finds the count at zero is an expiry. The counter reloads the start value. If bit 3 of 0x04 was clear, the expiry sets it.
- R6: An expiry while bit 3 of 0x04 is set also sets bit 1 of 0x06. With reboot-block at 0, `rst_req` goes high for exactly one cycle, in the cycle after that expiry edge.
- R7: With reboot-block at 1, expiries still update both status bits, but `rst_req` stays 0.
- R8: Status bits clear only when a 1 is written to them. Writing 0 leaves them as they are. The boot flag at bit 2 of 0x06 clears the same way.
- R9: If a clear of bit 3 of 0x04 lands on the same edge as an expiry, the bit stays set.
- R10: A write to 0x00 on the same edge as an expiry cancels the expiry: no status bit changes and the counter holds the start value.
- R11: After a reset request, the counter reloads and keeps running. A later unserviced expiry raises another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench lines up a status clear with an expiry on the same edge, and does the same with a service write. A design that let the clear win would lose the first timeout and allow an extra grace period. A design that let the expiry win over the service write would raise a timeout that software had prevented. It also checks that the reset request is exactly one cycle wide and falls on the second expiry rather than the first, and that it stays silent while reboots are blocked. Reloading the count on the wrong tick, or losing the phase after a halt, would shift every expiry cycle the bench predicts. The bench also writes start values below four. A design that accepted them would change every later expiry time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 10;
  localparam int MIN_INIT = 4;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS_A = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STS_B = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 5'h12;

  localparam int BIT_TO1   = 3;
  localparam int BIT_TO2   = 1;
  localparam int BIT_BOOT  = 2;
  localparam int BIT_HALT  = 11;
  localparam int BIT_NOREB = 0;

  typedef struct packed {
    logic count_wr;
    logic sts_a_wr;
    logic sts_b_wr;
    logic ctrl_wr;
    logic init_wr;
  } wr_dec_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_addr_dec.sv
module wdt_addr_dec
  import wdt_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_dec_t           strobe
);
  logic wr_ok;

  always_comb begin
    wr_ok           = sel & wr;
    strobe          = '0;
    strobe.count_wr = wr_ok & (addr == OFS_COUNT);
    strobe.sts_a_wr = wr_ok & (addr == OFS_STS_A);
    strobe.sts_b_wr = wr_ok & (addr == OFS_STS_B);
    strobe.ctrl_wr  = wr_ok & (addr == OFS_CTRL);
    strobe.init_wr  = wr_ok & (addr == OFS_INIT);
  end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic          ph_en;
  logic          at_last;

  always_comb begin
    at_last = (ph_q == LAST);
    ph_en   = restart | run;
    if (restart || at_last) ph_d = '0;
    else                    ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign tick = run & at_last & ~restart;
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W     = 10,
  parameter int RESET_VAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    expire = tick & ~reload & (cnt_q == '0);
    cnt_en = reload | tick;
    if (reload || expire) cnt_d = start_val;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RESET_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
#(
  parameter int RESET_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_dec_t           strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              halt,
  output logic              noreb,
  output logic [CNT_W-1:0]  init_lo,
  output logic [DATA_W-CNT_W-1:0] init_hi,
  output logic              sts_to1,
  output logic              sts_to2,
  output logic              sts_boot,
  output logic              rst_req
);
  localparam int HI_W = DATA_W - CNT_W;

  logic halt_q, halt_d, noreb_q, noreb_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic to1_q, to1_d, to2_q, to2_d, boot_q, boot_d;
  logic req_q, req_d;
  logic second_exp, lo_valid;

  always_comb begin
    halt_d  = strobe.ctrl_wr ? wdata[BIT_HALT]  : halt_q;
    noreb_d = strobe.ctrl_wr ? wdata[BIT_NOREB] : noreb_q;

    lo_valid = (wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT));
    hi_d = strobe.init_wr ? wdata[DATA_W-1:CNT_W] : hi_q;
    lo_d = (strobe.init_wr && lo_valid) ? wdata[CNT_W-1:0] : lo_q;

    second_exp = expire & to1_q;
    to1_d  = expire     | (to1_q  & ~(strobe.sts_a_wr & wdata[BIT_TO1]));
    to2_d  = second_exp | (to2_q  & ~(strobe.sts_b_wr & wdata[BIT_TO2]));
    boot_d = boot_q & ~(strobe.sts_b_wr & wdata[BIT_BOOT]);
    req_d  = second_exp & ~noreb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b1;
      noreb_q <= 1'b1;
      lo_q    <= CNT_W'(RESET_INIT);
      hi_q    <= '0;
      to1_q   <= 1'b0;
      to2_q   <= 1'b0;
      boot_q  <= 1'b1;
      req_q   <= 1'b0;
    end else begin
      halt_q  <= halt_d;
      noreb_q <= noreb_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      to1_q   <= to1_d;
      to2_q   <= to2_d;
      boot_q  <= boot_d;
      req_q   <= req_d;
    end
  end

  assign halt     = halt_q;
  assign noreb    = noreb_q;
  assign init_lo  = lo_q;
  assign init_hi  = hi_q;
  assign sts_to1  = to1_q;
  assign sts_to2  = to2_q;
  assign sts_boot = boot_q;
  assign rst_req  = req_q;
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int TICK_CYCLES = 16,
  parameter int RESET_INIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int HI_W = DATA_W - CNT_W;

  logic             rst_n_sync;
  wr_dec_t          strobe;
  logic             reload_wr;
  logic             tick, expire;
  logic             halt, noreb;
  logic [CNT_W-1:0] count, init_lo;
  logic [HI_W-1:0]  init_hi;
  logic             sts_to1, sts_to2, sts_boot;

  wdt_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  wdt_addr_dec u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .strobe(strobe)
  );

  assign reload_wr = strobe.count_wr;

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n_sync), .run(~halt), .restart(reload_wr), .tick(tick)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .RESET_VAL(RESET_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .reload(reload_wr),
    .start_val(init_lo), .count(count), .expire(expire)
  );

  wdt_csr #(.RESET_INIT(RESET_INIT)) u_csr (
    .clk(clk), .rst_n(rst_n_sync), .strobe(strobe), .wdata(bus_wdata),
    .expire(expire), .halt(halt), .noreb(noreb), .init_lo(init_lo),
    .init_hi(init_hi), .sts_to1(sts_to1), .sts_to2(sts_to2),
    .sts_boot(sts_boot), .rst_req(rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_COUNT: bus_rdata[CNT_W-1:0] = count;
      OFS_STS_A: bus_rdata[BIT_TO1]   = sts_to1;
      OFS_STS_B: begin
        bus_rdata[BIT_TO2]  = sts_to2;
        bus_rdata[BIT_BOOT] = sts_boot;
      end
      OFS_CTRL: begin
        bus_rdata[BIT_HALT]  = halt;
        bus_rdata[BIT_NOREB] = noreb;
      end
      OFS_INIT:  bus_rdata = {init_hi, init_lo};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             halt,
  input logic             noreb,
  input logic             reload_wr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_lo,
  input logic             sts_to1,
  input logic             sts_to2
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6

  AST_NOREB_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(noreb)); // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(count)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_wr && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1)); // R2

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (count == $past(init_lo) && !$rose(sts_to1))); // R10

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_to2) |-> $past(sts_to1)); // R6

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    init_lo >= CNT_W'(4)); // R4
endmodule

bind twostage_wdt wdt_checker #(.CNT_W(wdt_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .halt(halt), .noreb(noreb),
  .reload_wr(reload_wr), .count(count), .init_lo(init_lo),
  .sts_to1(sts_to1), .sts_to2(sts_to2)
);

// File: tb/tb_twostage_wdt.sv
`timescale 1ns/100ps
module tb_twostage_wdt;
  localparam int T = 4;
  localparam logic [4:0] A_CNT = 5'h00, A_STA = 5'h04, A_STB = 5'h06,
                         A_CTL = 5'h08, A_INI = 5'h12;
  localparam int K_RD = 0, K_REQ = 1, K_PULSES = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr;
  logic [4:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic rst_req;

  int n_cmp = 0, n_fail = 0, pulse_cnt = 0;
  bit done = 0;

  int          q_kind[$];
  logic [4:0]  q_addr[$];
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  twostage_wdt #(.TICK_CYCLES(T), .RESET_INIT(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  // Monitor: pops expected items and compares them with what the design shows
  always @(negedge clk) begin
    if (rst_n && rst_req) pulse_cnt++;
    if (q_kind.size() > 0) begin
      int k;
      logic [4:0] a;
      logic [15:0] e, act;
      string t;
      k = q_kind.pop_front(); a = q_addr.pop_front();
      e = q_exp.pop_front();  t = q_tag.pop_front();
      case (k)
        K_RD:    act = bus_rdata;
        K_REQ:   act = {15'd0, rst_req};
        default: act = pulse_cnt[15:0];
      endcase
      n_cmp++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s kind=%0d addr=0x%02h actual=0x%04h expected=0x%04h", t, k, a, act, e);
      end
    end
  end

  task automatic expect_item(input int k, input logic [4:0] a, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    q_kind.push_back(k); q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_edges(3);

    // R1 reset state
    expect_item(K_RD, A_CTL, 16'h0801, "R1");
    expect_item(K_RD, A_CNT, 16'h0004, "R1");
    expect_item(K_RD, A_INI, 16'h0004, "R1");
    expect_item(K_RD, A_STA, 16'h0000, "R1");
    expect_item(K_RD, A_STB, 16'h0004, "R1");
    expect_item(K_REQ, A_CNT, 16'h0000, "R1");
    // R2 halted from reset
    wait_edges(20);
    expect_item(K_RD, A_CNT, 16'h0004, "R2");

    // R4 start-value register
    wr(A_INI, 16'hFC02); expect_item(K_RD, A_INI, 16'hFC04, "R4");
    wr(A_INI, 16'h03FF); expect_item(K_RD, A_INI, 16'h03FF, "R4");
    wr(A_INI, 16'h0003); expect_item(K_RD, A_INI, 16'h03FF, "R4");
    wr(A_INI, 16'h0004); expect_item(K_RD, A_INI, 16'h0004, "R4");
    wr(A_INI, 16'h0006); expect_item(K_RD, A_INI, 16'h0006, "R4");

    // R3 reload while halted
    wr(A_CNT, 16'h1234); expect_item(K_RD, A_CNT, 16'h0006, "R3");

    // R2 / R5 timing with reboot blocked
    wr(A_CTL, 16'h0001);
    wr(A_CNT, 16'hFFFF);
    wait_edges(T - 2);
    expect_item(K_RD, A_CNT, 16'h0006, "R2");
    expect_item(K_RD, A_CNT, 16'h0005, "R2");
    wait_edges(22);
    expect_item(K_RD, A_STA, 16'h0000, "R5");
    expect_item(K_RD, A_STA, 16'h0008, "R5");
    expect_item(K_RD, A_CNT, 16'h0006, "R5");
    // R7 second expiry with reboot blocked
    wait_edges(40);
    expect_item(K_RD, A_STB, 16'h0006, "R7");
    expect_item(K_PULSES, A_CNT, 16'd0, "R7");

    // R8 write-one-to-clear, while halted
    wr(A_CTL, 16'h0801);
    wr(A_STB, 16'h0000); expect_item(K_RD, A_STB, 16'h0006, "R8");
    wr(A_STB, 16'h0002); expect_item(K_RD, A_STB, 16'h0004, "R8");
    wr(A_STB, 16'h0004); expect_item(K_RD, A_STB, 16'h0000, "R8");
    wr(A_STA, 16'hFFF7); expect_item(K_RD, A_STA, 16'h0008, "R8");
    wr(A_STA, 16'h0008); expect_item(K_RD, A_STA, 16'h0000, "R8");

    // R6 reset request on second expiry, R11 keeps running
    wr(A_CTL, 16'h0000);
    wr(A_CNT, 16'h0000);
    wait_edges(54);
    expect_item(K_REQ, A_CNT, 16'h0000, "R6");
    expect_item(K_REQ, A_CNT, 16'h0001, "R6");
    expect_item(K_REQ, A_CNT, 16'h0000, "R6");
    expect_item(K_RD, A_STB, 16'h0002, "R6");
    wait_edges(1);
    expect_item(K_RD, A_CNT, 16'h0005, "R11");
    wait_edges(30);
    wr(A_CTL, 16'h0801);
    expect_item(K_PULSES, A_CNT, 16'd2, "R11");

    // R9 clear collides with expiry: set wins
    wr(A_STA, 16'h0008); expect_item(K_RD, A_STA, 16'h0000, "R9");
    wr(A_CTL, 16'h0001);
    wr(A_CNT, 16'h0000);
    wait_edges(26);
    wr(A_STA, 16'h0008);
    expect_item(K_RD, A_STA, 16'h0008, "R9");
    wr(A_CTL, 16'h0801);

    // R10 reload collides with expiry: reload wins
    wr(A_STA, 16'h0008); expect_item(K_RD, A_STA, 16'h0000, "R10");
    wr(A_CTL, 16'h0001);
    wr(A_CNT, 16'h0000);
    wait_edges(26);
    wr(A_CNT, 16'h0000);
    expect_item(K_RD, A_STA, 16'h0000, "R10");
    expect_item(K_RD, A_CNT, 16'h0006, "R10");

    // R2 halt freezes a running count
    wait_edges(8);
    wr(A_CTL, 16'h0801);
    wait_edges(20);
    expect_item(K_RD, A_CNT, 16'h0003, "R2");

    wait_edges(3);
    done = 1;
    summary();
    $finish;
  end
endmodule